// File: doc/BRIEF.md
# ACPI Sleep-State Power Sequencer

This controller runs from the standby supply and moves a platform between the working state S0, the light sleep S1, and the deeper states S3 (suspend to memory), S4 (hibernate) and S5 (soft off). It releases the resume-well reset once the standby rail has been good for a fixed number of clocks. It decodes the current sleep depth onto three active-low sleep lines and derives the active-low main-supply enable from the shallowest of those lines.

It watches four kinds of input. The first is a front-panel button, which is active low and pulled up to standby power; it is synchronised and debounced here. The second is a wake-event input. The third is a software request that names a target sleep state. The fourth is a pair of comparator flags for the 3.3 V and 5 V main rails. The platform reset is held until both rails are good and have stayed good for a set delay in S0. If the main rails never come up after power-up starts, a fault flag is raised and the controller falls back to soft off.

Top module: `pwrseq_ctrl`

## Requirements
- R1: While rst_n is low, rsmrst_n_o is 0, all three sleep lines are 0, ps_on_n_o is 1, pltrst_n_o is 0 and fault_o is 0.
- R2: The sleep lines {slp_s3_n_o, slp_s4_n_o, slp_s5_n_o} are 111 in S0, in S1 and during power-up, 011 in S3, 001 in S4 and 000 in S5. pltrst_n_o is 0 in S1.
- R3: ps_on_n_o is always the inverse of slp_s3_n_o.
- R4: rsmrst_n_o goes to 1 exactly RSM_DLY_CYC clock edges after sb_good_i rises. It returns to 0 in the same cycle that sb_good_i falls, and the next rise restarts the full delay. While rsmrst_n_o is 0, the controller is held in S5 and the button is ignored.
- R5: A button level that stays low for DEB_CYC consecutive synchronised samples gives exactly one event. A low pulse of DEB_CYC-1 cycles has no effect.
- R6: In S5, a button event starts power-up. wake_i has no effect in S5.
- R7: In S3 or S4, either a button event or wake_i starts power-up.
- R8: In S0, a button event moves to the state chosen by btn_act_i: 01 selects S3, 10 selects S4, and 00 or 11 selects S5.
- R9: In S0, a pulse on sw_req_i moves to the state given by sw_tgt_i: 00 selects S1, 01 selects S3, 10 selects S4 and 11 selects S5. sw_req_i is ignored in every other state.
- R10: Power good is v33_ok_i AND v5_ok_i. pltrst_n_o goes to 1 exactly PLT_DLY_CYC edges after the controller is in S0 with power good high. It drops in the same cycle that power good falls, and within one clock of leaving S0.
- R11: During power-up, once power good is seen the controller enters S0. If power good is absent for PG_TMO_CYC cycles, fault_o goes to 1 and the controller returns to S5. The next start of power-up clears fault_o.
- R12: In S1, a button event or wake_i returns the controller to S0 without ever dropping the sleep lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Standby-domain clock |
| rst_n | input | 1 | Active-low asynchronous reset of the standby logic |
| sb_good_i | input | 1 | Standby rail above its trip level |
| pwrbtn_n_i | input | 1 | Raw front-panel button, active low |
| wake_i | input | 1 | Wake event |
| sw_req_i | input | 1 | Software sleep request strobe |
| sw_tgt_i | input | 2 | Requested state: 00 S1, 01 S3, 10 S4, 11 S5 |
| btn_act_i | input | 2 | Button action in S0: 01 S3, 10 S4, other S5 |
| v33_ok_i | input | 1 | 3.3 V rail at least 95 % of nominal |
| v5_ok_i | input | 1 | 5 V rail at least 95 % of nominal |
| rsmrst_n_o | output | 1 | Resume-well reset, active low |
| slp_s3_n_o | output | 1 | Sleep line for S3 and deeper, active low |
| slp_s4_n_o | output | 1 | Sleep line for S4 and deeper, active low |
| slp_s5_n_o | output | 1 | Sleep line for S5, active low |
| ps_on_n_o | output | 1 | Main supply enable, active low |
| pltrst_n_o | output | 1 | Platform reset, active low |
| fault_o | output | 1 | Main rails failed to come up in time |

## Verification
The state machine is driven along several paths. Power-up is started by the button from S5, by wake_i from S3, and by the button from S4. Sleep entry is made by software request to each of the four targets and by the button under each action code. Comparing the three sleep lines with the platform reset separates S0, S1 and the deeper states.

A one-cycle-short button pulse is set against a full-length press to find the debounce edge. wake_i and software requests are applied in states where they must do nothing. Standby loss and its return show that the resume-reset delay restarts in full. Holding the rails low during power-up exercises the timeout, and dropping power good in S0 shows the exact release edge of the platform reset.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [2:0] {
    ST_S5 = 3'd0,
    ST_S4 = 3'd1,
    ST_S3 = 3'd2,
    ST_S1 = 3'd3,
    ST_UP = 3'd4,
    ST_S0 = 3'd5
  } pstate_e;

  // {slp_s3_n, slp_s4_n, slp_s5_n}: deeper states pull more lines low
  function automatic logic [2:0] slp_lines(pstate_e s);
    case (s)
      ST_S5:   return 3'b000;
      ST_S4:   return 3'b001;
      ST_S3:   return 3'b011;
      default: return 3'b111;
    endcase
  endfunction

  function automatic pstate_e sw_target(logic [1:0] code);
    case (code)
      2'b00:   return ST_S1;
      2'b01:   return ST_S3;
      2'b10:   return ST_S4;
      default: return ST_S5;
    endcase
  endfunction

  function automatic pstate_e btn_target(logic [1:0] code);
    case (code)
      2'b01:   return ST_S3;
      2'b10:   return ST_S4;
      default: return ST_S5;
    endcase
  endfunction

  function automatic logic power_good(logic v33, logic v5);
    return v33 & v5;
  endfunction

endpackage

// File: rtl/pwrseq_debounce.sv
module pwrseq_debounce #(
  parameter int SYNC_STAGES = 2,
  parameter int DEB_CYC     = 125000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_n,
  output logic press_evt
);
  localparam int CW = $clog2(DEB_CYC + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          low_cnt;
  logic                   low_s;

  // idle level of the button is high, so the chain resets to ones
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], btn_n};
  end

  assign low_s = ~sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      low_cnt <= '0;
    else if (!low_s)                 low_cnt <= '0;
    else if (low_cnt != CW'(DEB_CYC)) low_cnt <= low_cnt + 1'b1;
  end

  // fires on the DEB_CYC-th low sample, then the counter parks until release
  assign press_evt = low_s && (low_cnt == CW'(DEB_CYC - 1));

endmodule

// File: rtl/pwrseq_hold_cnt.sv
module pwrseq_hold_cnt #(
  parameter int LIMIT = 4000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic done
);
  localparam int W = $clog2(LIMIT + 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!en)              cnt <= '0;
    else if (cnt != W'(LIMIT)) cnt <= cnt + 1'b1;
  end

  // gated by en so that loss of the condition is seen in the same cycle
  assign done = en && (cnt == W'(LIMIT));

endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
  import pwrseq_pkg::*;
#(
  parameter int PG_TMO_CYC = 62500000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       btn_evt,
  input  logic       wake,
  input  logic       sw_req,
  input  logic [1:0] sw_tgt,
  input  logic [1:0] btn_act,
  input  logic       pg,
  output pstate_e    state,
  output logic       fault
);
  localparam int TW = $clog2(PG_TMO_CYC + 1);

  logic [TW-1:0] tmo_cnt;
  logic          tmo_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               tmo_cnt <= '0;
    else if (state != ST_UP)  tmo_cnt <= '0;
    else                      tmo_cnt <= tmo_cnt + 1'b1;
  end

  assign tmo_hit = (state == ST_UP) && !pg && (tmo_cnt == TW'(PG_TMO_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_S5;
      fault <= 1'b0;
    end else if (!run) begin
      state <= ST_S5;
      fault <= 1'b0;
    end else begin
      case (state)
        ST_S5: if (btn_evt) begin
          state <= ST_UP;
          fault <= 1'b0;
        end
        ST_S4, ST_S3: if (btn_evt || wake) begin
          state <= ST_UP;
          fault <= 1'b0;
        end
        ST_S1: if (btn_evt || wake) state <= ST_S0;
        ST_UP: begin
          if (pg) state <= ST_S0;
          else if (tmo_hit) begin
            state <= ST_S5;
            fault <= 1'b1;
          end
        end
        ST_S0: begin
          if (sw_req)       state <= sw_target(sw_tgt);
          else if (btn_evt) state <= btn_target(btn_act);
        end
        default: state <= ST_S5;
      endcase
    end
  end

endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
  import pwrseq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DEB_CYC     = 125000,
  parameter int RSM_DLY_CYC = 4000000,
  parameter int PLT_DLY_CYC = 12500000,
  parameter int PG_TMO_CYC  = 62500000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sb_good_i,
  input  logic       pwrbtn_n_i,
  input  logic       wake_i,
  input  logic       sw_req_i,
  input  logic [1:0] sw_tgt_i,
  input  logic [1:0] btn_act_i,
  input  logic       v33_ok_i,
  input  logic       v5_ok_i,
  output logic       rsmrst_n_o,
  output logic       slp_s3_n_o,
  output logic       slp_s4_n_o,
  output logic       slp_s5_n_o,
  output logic       ps_on_n_o,
  output logic       pltrst_n_o,
  output logic       fault_o
);
  logic       btn_evt;
  logic       pg;
  logic       rsm_ok;
  logic       plt_en;
  logic       plt_ok;
  logic [2:0] lines;
  pstate_e    state;

  assign pg = power_good(v33_ok_i, v5_ok_i);

  pwrseq_hold_cnt #(.LIMIT(RSM_DLY_CYC)) u_rsm (
    .clk(clk), .rst_n(rst_n), .en(sb_good_i), .done(rsm_ok)
  );

  pwrseq_debounce #(.SYNC_STAGES(SYNC_STAGES), .DEB_CYC(DEB_CYC)) u_deb (
    .clk(clk), .rst_n(rst_n), .btn_n(pwrbtn_n_i), .press_evt(btn_evt)
  );

  pwrseq_fsm #(.PG_TMO_CYC(PG_TMO_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .run(rsm_ok), .btn_evt(btn_evt),
    .wake(wake_i), .sw_req(sw_req_i), .sw_tgt(sw_tgt_i),
    .btn_act(btn_act_i), .pg(pg), .state(state), .fault(fault_o)
  );

  assign plt_en = (state == ST_S0) && pg;

  pwrseq_hold_cnt #(.LIMIT(PLT_DLY_CYC)) u_plt (
    .clk(clk), .rst_n(rst_n), .en(plt_en), .done(plt_ok)
  );

  assign lines      = slp_lines(state);
  assign slp_s3_n_o = lines[2];
  assign slp_s4_n_o = lines[1];
  assign slp_s5_n_o = lines[0];
  assign ps_on_n_o  = ~lines[2];
  assign rsmrst_n_o = rsm_ok;
  assign pltrst_n_o = plt_ok;

endmodule

// File: rtl/pwrseq_chk.sv
module pwrseq_chk (
  input logic clk,
  input logic rst_n,
  input logic sb_good_i,
  input logic v33_ok_i,
  input logic v5_ok_i,
  input logic rsmrst_n_o,
  input logic slp_s3_n_o,
  input logic slp_s4_n_o,
  input logic slp_s5_n_o,
  input logic ps_on_n_o,
  input logic pltrst_n_o,
  input logic fault_o,
  input logic btn_evt
);
  // R2: a deeper line is never low while a shallower one is high
  a_r2_depth_order_s4: assert property (@(posedge clk) disable iff (!rst_n)
    !slp_s4_n_o |-> !slp_s3_n_o);
  a_r2_depth_order_s5: assert property (@(posedge clk) disable iff (!rst_n)
    !slp_s5_n_o |-> !slp_s4_n_o);

  // R3
  a_r3_supply_tracks_s3: assert property (@(posedge clk) disable iff (!rst_n)
    ps_on_n_o != slp_s3_n_o);

  // R4
  a_r4_rsm_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !sb_good_i |-> !rsmrst_n_o);
  a_r4_held_off: assert property (@(posedge clk) disable iff (!rst_n)
    !rsmrst_n_o |=> !slp_s5_n_o);

  // R5
  a_r5_single_event: assert property (@(posedge clk) disable iff (!rst_n)
    btn_evt |=> !btn_evt);

  // R10
  a_r10_plt_needs_pg: assert property (@(posedge clk) disable iff (!rst_n)
    !(v33_ok_i && v5_ok_i) |-> !pltrst_n_o);
  a_r10_plt_only_awake: assert property (@(posedge clk) disable iff (!rst_n)
    !slp_s3_n_o |-> !pltrst_n_o);

  // R11
  a_r11_fault_to_off: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_o) |-> !slp_s5_n_o);

endmodule

bind pwrseq_ctrl pwrseq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sb_good_i(sb_good_i), .v33_ok_i(v33_ok_i),
  .v5_ok_i(v5_ok_i), .rsmrst_n_o(rsmrst_n_o), .slp_s3_n_o(slp_s3_n_o),
  .slp_s4_n_o(slp_s4_n_o), .slp_s5_n_o(slp_s5_n_o), .ps_on_n_o(ps_on_n_o),
  .pltrst_n_o(pltrst_n_o), .fault_o(fault_o), .btn_evt(btn_evt)
);

// File: tb/tb_pwrseq_ctrl.sv
module tb_pwrseq_ctrl;
  localparam int DEB = 4;
  localparam int RSM = 40;
  localparam int PLT = 10;
  localparam int TMO = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sb_good = 1'b0;
  logic btn_n = 1'b1;
  logic wake = 1'b0;
  logic sw_req = 1'b0;
  logic [1:0] sw_tgt = 2'b00;
  logic [1:0] btn_act = 2'b11;
  logic v33 = 1'b0;
  logic v5 = 1'b0;
  logic rsmrst_n, s3_n, s4_n, s5_n, ps_on_n, pltrst_n, fault;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pwrseq_ctrl #(.SYNC_STAGES(2), .DEB_CYC(DEB), .RSM_DLY_CYC(RSM),
                .PLT_DLY_CYC(PLT), .PG_TMO_CYC(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .sb_good_i(sb_good), .pwrbtn_n_i(btn_n),
    .wake_i(wake), .sw_req_i(sw_req), .sw_tgt_i(sw_tgt), .btn_act_i(btn_act),
    .v33_ok_i(v33), .v5_ok_i(v5), .rsmrst_n_o(rsmrst_n), .slp_s3_n_o(s3_n),
    .slp_s4_n_o(s4_n), .slp_s5_n_o(s5_n), .ps_on_n_o(ps_on_n),
    .pltrst_n_o(pltrst_n), .fault_o(fault)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] lines();
    return {1'b0, s3_n, s4_n, s5_n};
  endfunction

  task automatic press();
    btn_n = 1'b0;
    tick(DEB + 4);
    btn_n = 1'b1;
    tick(4);
  endtask

  task automatic sw_pulse(input logic [1:0] t);
    sw_tgt = t; sw_req = 1'b1;
    tick(1);
    sw_req = 1'b0;
    tick(2);
  endtask

  task automatic wake_pulse();
    wake = 1'b1;
    tick(1);
    wake = 1'b0;
    tick(3);
  endtask

  task automatic t_reset();
    tick(2);
    check("R1 rsmrst", {3'b0, rsmrst_n}, 4'd0);
    check("R1 lines", lines(), 4'b0000);
    check("R1 ps_on", {3'b0, ps_on_n}, 4'd1);
    check("R1 pltrst/fault", {2'b0, pltrst_n, fault}, 4'b0000);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic t_rsm_startup();
    press();  // R4: ignored while resume reset is held
    check("R4 button ignored in reset", lines(), 4'b0000);
    sb_good = 1'b1;
    tick(RSM - 1);
    check("R4 not yet released", {3'b0, rsmrst_n}, 4'd0);
    tick(1);
    check("R4 released", {3'b0, rsmrst_n}, 4'd1);
  endtask

  task automatic t_s5_ignores();
    v33 = 1'b1; v5 = 1'b1;
    btn_n = 1'b0;
    tick(DEB - 1);
    btn_n = 1'b1;
    tick(6);
    check("R5 short pulse ignored", lines(), 4'b0000);
    wake_pulse();
    check("R6 wake ignored in S5", lines(), 4'b0000);
    sw_pulse(2'b00);
    check("R9 request ignored in S5", lines(), 4'b0000);
  endtask

  task automatic t_power_up();
    press();
    check("R6 button powers up", lines(), 4'b0111);
    check("R3 supply on", {3'b0, ps_on_n}, 4'd0);
    tick(PLT + 2);
    check("R10 pltrst released", {3'b0, pltrst_n}, 4'd1);
    v5 = 1'b0;
    #1;
    check("R10 pltrst on pg loss", {3'b0, pltrst_n}, 4'd0);
    tick(1);
    v5 = 1'b1;
    tick(PLT - 1);
    check("R10 still held", {3'b0, pltrst_n}, 4'd0);
    tick(1);
    check("R10 exact release", {3'b0, pltrst_n}, 4'd1);
  endtask

  task automatic t_s1();
    sw_pulse(2'b00);
    check("R2 S1 lines", lines(), 4'b0111);
    check("R2 S1 pltrst", {3'b0, pltrst_n}, 4'd0);
    wake_pulse();
    check("R12 S1 wake lines", lines(), 4'b0111);
    tick(PLT);
    check("R12 back in S0", {3'b0, pltrst_n}, 4'd1);
  endtask

  task automatic t_s3_s4();
    sw_pulse(2'b01);
    check("R9 S3 lines", lines(), 4'b0011);
    check("R3 supply off", {3'b0, ps_on_n}, 4'd1);
    sw_pulse(2'b11);
    check("R9 request ignored in S3", lines(), 4'b0011);
    wake_pulse();
    check("R7 S3 wake", lines(), 4'b0111);
    tick(PLT);
    check("R7 S3 wake reaches S0", {3'b0, pltrst_n}, 4'd1);
    btn_act = 2'b10;
    press();
    check("R8 button to S4", lines(), 4'b0001);
    press();
    check("R7 S4 button wake", lines(), 4'b0111);
    tick(PLT);
    btn_act = 2'b01;
    press();
    check("R8 button to S3", lines(), 4'b0011);
    wake_pulse();
    tick(PLT);
    btn_act = 2'b00;
    press();
    check("R8 button code 00 to S5", lines(), 4'b0000);
    press();
    tick(PLT);
    sw_pulse(2'b10);
    check("R9 request S4", lines(), 4'b0001);
    wake_pulse();
    tick(PLT);
    sw_pulse(2'b11);
    check("R9 request S5", lines(), 4'b0000);
  endtask

  task automatic t_timeout();
    v33 = 1'b0;
    press();
    check("R11 waiting for pg", lines(), 4'b0111);
    check("R11 no fault yet", {3'b0, fault}, 4'd0);
    tick(TMO);
    check("R11 fault raised", {3'b0, fault}, 4'd1);
    check("R11 back to S5", lines(), 4'b0000);
    v33 = 1'b1;
    press();
    check("R11 fault cleared", {3'b0, fault}, 4'd0);
    check("R11 power up again", lines(), 4'b0111);
    tick(PLT);
    check("R11 reaches S0", {3'b0, pltrst_n}, 4'd1);
  endtask

  task automatic t_sb_loss();
    sb_good = 1'b0;
    #1;
    check("R4 immediate reassert", {3'b0, rsmrst_n}, 4'd0);
    tick(1);
    check("R4 forced to S5", lines(), 4'b0000);
    sb_good = 1'b1;
    tick(RSM - 1);
    check("R4 full delay restarted", {3'b0, rsmrst_n}, 4'd0);
    tick(1);
    check("R4 released again", {3'b0, rsmrst_n}, 4'd1);
  endtask

  initial begin
    t_reset();
    t_rsm_startup();
    t_s5_ignores();
    t_power_up();
    t_s1();
    t_s3_s4();
    t_timeout();
    t_sb_loss();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule